// File: doc/BRIEF.md
# Exception Priority and Vector Selector

This block sits beside a processor pipeline and receives up to seven exception request lines in the same cycle: reset, data-side abort, fast interrupt, normal interrupt, instruction-side abort, undefined instruction and software interrupt. It picks one by a fixed ranking and reports three things: a one-cycle taken strobe, a one-hot identifier of the chosen exception, and the 32-bit program-counter value where its handler starts. The outputs are registered, so a request sampled at one clock edge appears at the outputs right after that edge.

A high-vector control can move every handler address except the reset address from the zero base to a high base. The control is sampled at each edge, so a change affects only exceptions taken after it. A one-bit tracker records when a fast-interrupt handler is running. While that bit is set, normal interrupts are held off, but the other sources can still be taken. The bit is cleared by a return pulse, by taking the reset exception, or by the block's reset.

Top module: `exc_vector_sel`

## Requirements
- R1: The ranking from highest to lowest is reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction, software interrupt. `exc_id_o` is one-hot, with bit 0 for reset, bit 1 for data abort, bit 2 for fast interrupt, bit 3 for normal interrupt, bit 4 for prefetch abort, bit 5 for undefined instruction and bit 6 for software interrupt.
- R2: With `vec_hi_i` low, the vector is 0x00000000 for reset, 0x00000004 for undefined instruction, 0x00000008 for software interrupt, 0x0000000C for prefetch abort, 0x00000010 for data abort, 0x00000018 for normal interrupt and 0x0000001C for fast interrupt.
- R3: With `vec_hi_i` high, every vector except reset is 0xFFFF0000 plus its offset from R2 (for example, fast interrupt gives 0xFFFF001C). The reset vector is 0x00000000 in both cases.
- R4: `vec_hi_i` is sampled at each edge together with the requests. Toggling it between two consecutive exceptions changes only the vector of the later one.
- R5: Taking a fast interrupt sets an in-service state. While that state is set, a normal interrupt request is not taken: with nothing else pending, `taken_o` stays low, and a pending lower-ranked source is taken instead.
- R6: A pulse on `fiq_ret_i` sampled at an edge clears the in-service state at that edge. A normal interrupt sampled at that same edge is still masked; one sampled at the next edge is taken. Taking the reset exception also clears the state.
- R7: While `rst_ni` is low, `taken_o`, `exc_id_o` and `vector_o` are zero and the in-service state is cleared.
- R8: Requests sampled at edge k drive `taken_o`, `exc_id_o` and `vector_o` right after edge k. A request held for one cycle gives a strobe of exactly one cycle. When nothing is taken, `exc_id_o` is zero.
- R9: Undefined instruction and software interrupt are never raised together. Each one, raised alone, is identified by its own bit (5 and 6). If both are raised anyway, undefined instruction is selected and a simulation assertion reports the input error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_rst_i | input | 1 | Reset exception request |
| req_dabt_i | input | 1 | Data-side abort request |
| req_fiq_i | input | 1 | Fast interrupt request |
| req_irq_i | input | 1 | Normal interrupt request |
| req_pabt_i | input | 1 | Instruction-side abort request |
| req_und_i | input | 1 | Undefined instruction request |
| req_swi_i | input | 1 | Software interrupt request |
| vec_hi_i | input | 1 | Selects the high vector base |
| fiq_ret_i | input | 1 | Return pulse from the fast-interrupt handler |
| taken_o | output | 1 | Exception taken strobe |
| exc_id_o | output | 7 | One-hot identifier of the taken exception |
| vector_o | output | 32 | Handler address of the taken exception |

## Verification
Every result is due one edge after its stimulus. The bench drives inputs on the falling edge, waits for the next rising edge and samples 1 ns later, when all three registered outputs show the exception chosen from that sampled set. The in-service state adds one more edge of delay: a masked normal interrupt is re-presented one edge after the return pulse, and at that point the bench expects it to be taken. The asynchronous reset is checked 1 ns after `rst_ni` falls, with no clock edge in between.

// File: rtl/exc_pkg.sv
`timescale 1ns/1ps
package exc_pkg;
  localparam int unsigned EXC_NUM = 7;
  localparam int unsigned VEC_W   = 32;

  typedef enum logic [2:0] {
    EXC_RST  = 3'd0,
    EXC_DABT = 3'd1,
    EXC_FIQ  = 3'd2,
    EXC_IRQ  = 3'd3,
    EXC_PABT = 3'd4,
    EXC_UND  = 3'd5,
    EXC_SWI  = 3'd6
  } exc_idx_e;

  // Offset of each handler slot from the vector base.
  function automatic logic [VEC_W-1:0] exc_offset(input int unsigned idx);
    logic [VEC_W-1:0] off;
    case (idx)
      EXC_DABT: off = VEC_W'(32'h10);
      EXC_FIQ:  off = VEC_W'(32'h1C);
      EXC_IRQ:  off = VEC_W'(32'h18);
      EXC_PABT: off = VEC_W'(32'h0C);
      EXC_UND:  off = VEC_W'(32'h04);
      EXC_SWI:  off = VEC_W'(32'h08);
      default:  off = '0;
    endcase
    return off;
  endfunction

  // Full handler address; reset never moves.
  function automatic logic [VEC_W-1:0] exc_vector(input int unsigned idx,
                                                  input logic hi,
                                                  input logic [VEC_W-1:0] hi_base);
    if (idx == EXC_RST) return '0;
    return (hi ? hi_base : '0) | exc_offset(idx);
  endfunction
endpackage

// File: rtl/exc_prio_arb.sv
`timescale 1ns/1ps
module exc_prio_arb #(
  parameter int unsigned N = 7
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o,
  output logic         any_o
);
  // blocked[i] is set when some source of index below i is requesting
  logic [N:0] blocked;
  assign blocked[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_rank
    assign blocked[i+1] = blocked[i] | req_i[i];
    assign grant_o[i]   = req_i[i] & ~blocked[i];
  end

  assign any_o = blocked[N];
endmodule

// File: rtl/exc_vec_gen.sv
`timescale 1ns/1ps
module exc_vec_gen
  import exc_pkg::*;
#(
  parameter logic [VEC_W-1:0] HI_BASE = 32'hFFFF_0000
) (
  input  logic [EXC_NUM-1:0] grant_i,
  input  logic               hi_i,
  output logic [VEC_W-1:0]   vec_o
);
  always_comb begin
    vec_o = '0;
    for (int unsigned i = 0; i < EXC_NUM; i++) begin
      if (grant_i[i]) vec_o = vec_o | exc_vector(i, hi_i, HI_BASE);
    end
  end
endmodule

// File: rtl/exc_fiq_track.sv
`timescale 1ns/1ps
module exc_fiq_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_fiq_i,
  input  logic take_rst_i,
  input  logic ret_i,
  output logic busy_o
);
  logic busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 busy_q <= 1'b0;
    else if (take_fiq_i)         busy_q <= 1'b1;
    else if (ret_i || take_rst_i) busy_q <= 1'b0;
  end

  assign busy_o = busy_q;

  AST_FIQ_SETS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_fiq_i |=> busy_q); // R5
  AST_RET_CLEARS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ret_i || take_rst_i) && !take_fiq_i) |=> !busy_q); // R6
endmodule

// File: rtl/exc_vector_sel.sv
`timescale 1ns/1ps
module exc_vector_sel
  import exc_pkg::*;
#(
  parameter logic [31:0] HI_BASE = 32'hFFFF_0000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_rst_i,
  input  logic        req_dabt_i,
  input  logic        req_fiq_i,
  input  logic        req_irq_i,
  input  logic        req_pabt_i,
  input  logic        req_und_i,
  input  logic        req_swi_i,
  input  logic        vec_hi_i,
  input  logic        fiq_ret_i,
  output logic        taken_o,
  output logic [6:0]  exc_id_o,
  output logic [31:0] vector_o
);
  logic [EXC_NUM-1:0] raw_req;
  logic [EXC_NUM-1:0] elig_req;
  logic [EXC_NUM-1:0] grant;
  logic               grant_any;
  logic [VEC_W-1:0]   next_vec;
  logic               fiq_busy;
  logic               take_fiq;
  logic               take_rst;

  assign raw_req = {req_swi_i, req_und_i, req_pabt_i, req_irq_i,
                    req_fiq_i, req_dabt_i, req_rst_i};

  // Normal interrupt held off while the fast handler runs.
  always_comb begin
    elig_req = raw_req;
    elig_req[EXC_IRQ] = raw_req[EXC_IRQ] & ~fiq_busy;
  end

  exc_prio_arb #(.N(EXC_NUM)) u_arb (
    .req_i   (elig_req),
    .grant_o (grant),
    .any_o   (grant_any)
  );

  exc_vec_gen #(.HI_BASE(HI_BASE)) u_vec (
    .grant_i (grant),
    .hi_i    (vec_hi_i),
    .vec_o   (next_vec)
  );

  assign take_fiq = grant[EXC_FIQ];
  assign take_rst = grant[EXC_RST];

  exc_fiq_track u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_fiq_i (take_fiq),
    .take_rst_i (take_rst),
    .ret_i      (fiq_ret_i),
    .busy_o     (fiq_busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taken_o  <= 1'b0;
      exc_id_o <= '0;
      vector_o <= '0;
    end else begin
      taken_o  <= grant_any;
      exc_id_o <= grant;
      if (grant_any) vector_o <= next_vec;
    end
  end

  AST_ID_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(exc_id_o)); // R1
  AST_DABT_OUTRANKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_dabt_i && !req_rst_i) |=> exc_id_o[EXC_DABT]); // R1
  AST_RST_VEC_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_id_o[EXC_RST] |-> (vector_o == '0)); // R3
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_busy |-> !grant[EXC_IRQ]); // R5
  AST_STROBE_HAS_ID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o == (exc_id_o != '0)); // R8
  AST_UND_SWI_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_und_i && req_swi_i)); // R9
endmodule

// File: tb/exc_vector_sel_tb.sv
`timescale 1ns/1ps
module exc_vector_sel_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  req = '0;   // bit order: swi,und,pabt,irq,fiq,dabt,rst (6..0)
  logic        hi = 1'b0;
  logic        ret = 1'b0;
  logic        taken;
  logic [6:0]  id;
  logic [31:0] vec;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  exc_vector_sel dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_rst_i(req[0]), .req_dabt_i(req[1]), .req_fiq_i(req[2]),
    .req_irq_i(req[3]), .req_pabt_i(req[4]), .req_und_i(req[5]),
    .req_swi_i(req[6]), .vec_hi_i(hi), .fiq_ret_i(ret),
    .taken_o(taken), .exc_id_o(id), .vector_o(vec)
  );

  // Expected handler address, written independently as a lookup.
  function automatic logic [31:0] want_vec(input logic [6:0] oh, input logic h);
    logic [31:0] lo;
    unique case (oh)
      7'b0000001: return 32'h0;
      7'b0000010: lo = 32'h10;
      7'b0000100: lo = 32'h1C;
      7'b0001000: lo = 32'h18;
      7'b0010000: lo = 32'h0C;
      7'b0100000: lo = 32'h04;
      7'b1000000: lo = 32'h08;
      default:    return 32'h0;
    endcase
    return h ? (32'hFFFF0000 + lo) : lo;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // Present one cycle of inputs, then look at the outputs after the edge.
  task automatic step(input logic [6:0] r, input logic h, input logic rt);
    @(negedge clk);
    req = r; hi = h; ret = rt;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_take(input string tag, input logic [6:0] eid, input logic h);
    chk({tag, " taken"}, 32'(taken), 32'(eid != 0));
    chk({tag, " id"}, 32'(id), 32'(eid));
    if (eid != 0) chk({tag, " vector"}, vec, want_vec(eid, h));
  endtask

  // {requests, hi, expected id}
  localparam int NROW = 13;
  localparam logic [14:0] TABLE [NROW] = '{
    {7'b0000001, 1'b0, 7'b0000001},
    {7'b0000001, 1'b1, 7'b0000001},
    {7'b0000010, 1'b0, 7'b0000010},
    {7'b0000010, 1'b1, 7'b0000010},
    {7'b0001000, 1'b0, 7'b0001000},
    {7'b0010000, 1'b0, 7'b0010000},
    {7'b0100000, 1'b0, 7'b0100000},
    {7'b1000000, 1'b1, 7'b1000000},
    {7'b1011011, 1'b0, 7'b0000001},
    {7'b1011010, 1'b1, 7'b0000010},
    {7'b1011000, 1'b0, 7'b0001000},
    {7'b0110000, 1'b1, 7'b0010000},
    {7'b0000000, 1'b0, 7'b0000000}
  };

  initial begin
    #2; // asynchronous reset active from time zero
    @(posedge clk); #1;
    chk("R7 reset taken", 32'(taken), 0);
    chk("R7 reset id", 32'(id), 0);
    chk("R7 reset vector", vec, 0);
    @(negedge clk); rst_n = 1'b1;

    // R1 R2 R3 table of priority and vector cases
    for (int i = 0; i < NROW; i++) begin
      step(TABLE[i][14:8], TABLE[i][7], 1'b0);
      expect_take($sformatf("R1/R2/R3 row %0d", i), TABLE[i][6:0], TABLE[i][7]);
    end

    // R9: undefined and software interrupt each get their own bit
    step(7'b0100000, 1'b1, 1'b0);
    expect_take("R9 und alone", 7'b0100000, 1'b1);
    step(7'b1000000, 1'b0, 1'b0);
    expect_take("R9 swi alone", 7'b1000000, 1'b0);

    // R8: one-cycle request gives a one-cycle strobe
    step(7'b0010000, 1'b0, 1'b0);
    expect_take("R8 strobe on", 7'b0010000, 1'b0);
    step(7'b0000000, 1'b0, 1'b0);
    chk("R8 strobe off", 32'(taken), 0);
    chk("R8 id zero", 32'(id), 0);

    // R4: the base follows the control on each edge
    step(7'b0000010, 1'b1, 1'b0);
    chk("R4 high first", vec, 32'hFFFF0010);
    step(7'b0000010, 1'b0, 1'b0);
    chk("R4 low next", vec, 32'h00000010);

    // R5: fast outranks normal and then masks it
    step(7'b0001100, 1'b0, 1'b0);
    expect_take("R5 fiq over irq", 7'b0000100, 1'b0);
    step(7'b0001000, 1'b0, 1'b0);
    chk("R5 irq masked", 32'(taken), 0);
    step(7'b0011000, 1'b0, 1'b0);
    expect_take("R5 lower taken while masked", 7'b0010000, 1'b0);
    step(7'b0000100, 1'b1, 1'b0);
    expect_take("R3 fiq high", 7'b0000100, 1'b1);

    // R6: return pulse with irq in the same cycle; irq waits one edge
    step(7'b0001000, 1'b0, 1'b1);
    chk("R6 irq same edge as return", 32'(taken), 0);
    step(7'b0001000, 1'b0, 1'b0);
    expect_take("R6 irq after return", 7'b0001000, 1'b0);

    // R6: taking reset exception clears the in-service state
    step(7'b0000100, 1'b0, 1'b0);
    step(7'b0000001, 1'b0, 1'b0);
    expect_take("R6 reset exc", 7'b0000001, 1'b0);
    step(7'b0001000, 1'b0, 1'b0);
    expect_take("R6 irq after reset exc", 7'b0001000, 1'b0);

    // R7: the block reset clears outputs and in-service state
    step(7'b0000100, 1'b0, 1'b0);
    @(negedge clk); req = '0; rst_n = 1'b0;
    #1;
    chk("R7 async taken", 32'(taken), 0);
    chk("R7 async id", 32'(id), 0);
    chk("R7 async vector", vec, 0);
    @(negedge clk); rst_n = 1'b1;
    step(7'b0001000, 1'b0, 1'b0);
    expect_take("R7 irq after reset", 7'b0001000, 1'b0);
    step(7'b0000000, 1'b0, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule